// File: doc/BRIEF.md
# Immediate Register Load Unit

This unit builds 16-bit constants and word addresses for a small 16-bit processor whose instructions carry a 15-bit payload, made of three 5-bit fields. It owns the dedicated immediate register, which sits at index 28 of the 32-entry register file. A load operation writes the 15 payload bits into the low part of the register and clears the top bit. A separate set-high operation then raises bit 15 and leaves bits 14:0 as they are. Together the two operations produce any 16-bit data constant.

The unit also expands an address payload. Memory addresses are word-aligned, so their lowest bit is never encoded. The expanded address is the payload shifted left by one place, with a zero in bit 0. The register value is always visible on a read port, along with a flag that says whether a register-file read index selects the immediate register.

Top module: `imm_reg_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the immediate register becomes 0x0000 at that edge.
- R2: When `ld_low` is high and `set_high` is low, the register becomes {1'b0, payload[14:0]} after the edge, so bit 15 is cleared.
- R3: When `set_high` is high and `ld_low` is low, bit 15 becomes 1 after the edge and bits 14:0 keep their previous value.
- R4: When `ld_low` and `set_high` are both high, the register becomes {1'b1, payload[14:0]} after the edge.
- R5: When neither strobe is high, the register keeps its value, whatever the payload is.
- R6: `addr_out` equals {payload[14:0], 1'b0} in the same cycle (combinational), so `addr_out[0]` is always 0.
- R7: `imm_q` shows the new register value starting in the cycle after the update edge.
- R8: `rd_hit` is high exactly when `rd_idx` equals 28, the immediate register's index in the 32-entry register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| payload | input | 15 | Instruction payload: three 5-bit fields, with the upper field in bits 14:10 |
| ld_low | input | 1 | Load the payload into bits 14:0 and clear bit 15 |
| set_high | input | 1 | Set bit 15 of the register |
| rd_idx | input | 5 | Register-file read index to compare with 28 |
| imm_q | output | 16 | Current value of the immediate register |
| addr_out | output | 16 | Expanded word-aligned address |
| rd_hit | output | 1 | High when rd_idx selects the immediate register |

## Verification
The assertions check the following on every cycle against the value from the previous cycle:
- the reset result,
- the update rules for each strobe combination,
- holding the value when no strobe is active,
- the zero low bit and shifted layout of the address,
- the index match.

They cannot show that a sequence of operations builds the intended constant. Only the bench's scenarios show that a load followed by set-high builds the full 16-bit constant, and that a later load wipes out the top bit. The bench's scenarios also cover a reset issued in the middle of a sequence and the all-ones and alternating payload patterns.

// File: rtl/imm_pkg.sv
// Package: shared widths and constants for the immediate register unit.
// Assumes a 5-bit field width and three fields per payload.
package imm_pkg;
    localparam int FIELD_W   = 5;
    localparam int N_FIELDS  = 3;
    localparam int PAY_W     = FIELD_W * N_FIELDS;
    localparam int WORD_W    = PAY_W + 1;
    localparam int IDX_W     = 5;
    localparam logic [IDX_W-1:0] IMM_IDX = 5'd28;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_LOAD = 2'b01,
        OP_HIGH = 2'b10,
        OP_BOTH = 2'b11
    } imm_op_e;
endpackage

// File: rtl/imm_payload_join.sv
// Module: joins the three payload fields into one vector.
// Assumes field 0 is the least significant field.
module imm_payload_join #(
    parameter int FW = 5,
    parameter int NF = 3
) (
    input  logic [FW*NF-1:0] fields_in,
    output logic [FW*NF-1:0] joined
);
    // One assignment per field keeps each field in its own bit range.
    for (genvar g = 0; g < NF; g++) begin : g_field
        assign joined[g*FW +: FW] = fields_in[g*FW +: FW];
    end
endmodule

// File: rtl/imm_addr_expand.sv
// Module: expands a word-aligned address payload to a full byte address.
// Assumes the lowest address bit is always zero.
module imm_addr_expand #(
    parameter int PW = 15
) (
    input  logic [PW-1:0] pay,
    output logic [PW:0]   addr
);
    // Shift left by one place and put a zero in bit 0.
    always_comb begin
        addr = {pay, 1'b0};
    end
endmodule

// File: rtl/imm_reg_core.sv
// Module: holds the immediate register and applies the load and set-high rules.
// Assumes synchronous active-low reset. A load clears the top bit unless
// set-high is asserted in the same cycle.
module imm_reg_core #(
    parameter int PW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pay,
    input  logic          ld_low,
    input  logic          set_high,
    output logic [PW:0]   q
);
    import imm_pkg::*;

    imm_op_e      op;
    logic [PW:0]  nxt;

    // Encode the two strobes as one operation code.
    always_comb begin
        op = imm_op_e'({set_high, ld_low});
    end

    // Work out the next register value for the chosen operation.
    always_comb begin
        case (op)
            OP_LOAD: nxt = {1'b0, pay};
            OP_HIGH: nxt = {1'b1, q[PW-1:0]};
            OP_BOTH: nxt = {1'b1, pay};
            default: nxt = q;
        endcase
    end

    // Store the next value, or clear the register on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/imm_reg_unit.sv
// Top: immediate register load unit. Builds 16-bit constants from 15-bit
// payloads and expands word-aligned addresses.
// Assumes the payload is valid whenever a strobe is high.
module imm_reg_unit #(
    parameter int FIELD_W  = imm_pkg::FIELD_W,
    parameter int N_FIELDS = imm_pkg::N_FIELDS,
    parameter int IDX_W    = imm_pkg::IDX_W,
    parameter logic [IDX_W-1:0] SELF_IDX = imm_pkg::IMM_IDX
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [FIELD_W*N_FIELDS-1:0] payload,
    input  logic                        ld_low,
    input  logic                        set_high,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [FIELD_W*N_FIELDS:0]   imm_q,
    output logic [FIELD_W*N_FIELDS:0]   addr_out,
    output logic                        rd_hit
);
    localparam int PW = FIELD_W * N_FIELDS;

    logic [PW-1:0] pay_j;

    imm_payload_join #(.FW(FIELD_W), .NF(N_FIELDS)) u_join (
        .fields_in(payload),
        .joined   (pay_j)
    );

    imm_reg_core #(.PW(PW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pay     (pay_j),
        .ld_low  (ld_low),
        .set_high(set_high),
        .q       (imm_q)
    );

    imm_addr_expand #(.PW(PW)) u_addr (
        .pay (pay_j),
        .addr(addr_out)
    );

    // Flag a register-file read that selects the immediate register.
    always_comb begin
        rd_hit = (rd_idx == SELF_IDX);
    end
endmodule

// File: rtl/imm_reg_unit_chk.sv
// Checker: temporal properties of the immediate register unit, bound to the top module.
module imm_reg_unit_chk #(
    parameter int PW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] payload,
    input logic          ld_low,
    input logic          set_high,
    input logic [4:0]    rd_idx,
    input logic [PW:0]   imm_q,
    input logic [PW:0]   addr_out,
    input logic          rd_hit
);
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> imm_q == '0);

    a_r2_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_low && !set_high) |=> imm_q == {1'b0, $past(payload)});

    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (set_high && !ld_low) |=> (imm_q[PW] && imm_q[PW-1:0] == $past(imm_q[PW-1:0])));

    a_r4_both: assert property (@(posedge clk) disable iff (!rst_n)
        (set_high && ld_low) |=> imm_q == {1'b1, $past(payload)});

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_high && !ld_low) |=> $stable(imm_q));

    // R6: the expanded address always ends in a zero bit.
    always_comb begin
        a_r6_addr_lsb: assert (addr_out[0] == 1'b0);
    end

    a_r6_addr_shape: assert property (@(posedge clk) addr_out[PW:1] == payload);

    a_r8_index: assert property (@(posedge clk) rd_hit == (rd_idx == 5'd28));
endmodule

bind imm_reg_unit imm_reg_unit_chk #(.PW(FIELD_W*N_FIELDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .payload(payload), .ld_low(ld_low),
    .set_high(set_high), .rd_idx(rd_idx), .imm_q(imm_q),
    .addr_out(addr_out), .rd_hit(rd_hit)
);

// File: tb/test_imm_reg_unit.sv
// Bench: walks a vector table, then runs directed tests for reset and corner cases.
module test_imm_reg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] payload = '0;
    logic        ld_low = 1'b0;
    logic        set_high = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [15:0] imm_q, addr_out;
    logic        rd_hit;
    int checks = 0;
    int errors = 0;
    logic [15:0] model = '0;

    always #4 clk = ~clk;

    imm_reg_unit i_imm_reg_unit (
        .clk(clk), .rst_n(rst_n), .payload(payload), .ld_low(ld_low),
        .set_high(set_high), .rd_idx(rd_idx), .imm_q(imm_q),
        .addr_out(addr_out), .rd_hit(rd_hit)
    );

    // Each vector is {ld, hi, payload}.
    localparam int NV = 10;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b0, 15'h1234},
        {1'b0, 1'b1, 15'h7FFF},
        {1'b0, 1'b0, 15'h5555},
        {1'b1, 1'b0, 15'h7FFF},
        {1'b0, 1'b1, 15'h0000},
        {1'b1, 1'b1, 15'h2AAA},
        {1'b1, 1'b0, 15'h0001},
        {1'b0, 1'b0, 15'h3C3C},
        {1'b1, 1'b1, 15'h0000},
        {1'b1, 1'b0, 15'h5555}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation at an edge, update the model, and check the register afterwards.
    task automatic step(input logic l, input logic h, input logic [14:0] p, input string req);
        ld_low = l; set_high = h; payload = p;
        #1;
        chk("R6", addr_out, {p, 1'b0});
        if (l)      model = {h, p};
        else if (h) model = {1'b1, model[14:0]};
        @(posedge clk); #2;
        ld_low = 0; set_high = 0;
        chk(req, imm_q, model);
    endtask

    initial begin : watchdog
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        payload = 15'h7FFF; ld_low = 1;
        repeat (2) @(posedge clk);
        #2 chk("R1", imm_q, 16'h0000);
        ld_low = 0; rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string r;
            r = VEC[i][16] ? (VEC[i][15] ? "R4" : "R2") : (VEC[i][15] ? "R3" : "R5");
            step(VEC[i][16], VEC[i][15], VEC[i][14:0], r);
        end

        // Full constant 0xF00D: load, then set-high; value visible next cycle (R7).
        step(1, 0, 15'h700D, "R2");
        step(0, 1, 15'h0000, "R3");
        chk("R7", imm_q, 16'hF00D);

        // A new load wipes out the top bit.
        step(1, 0, 15'h0042, "R2");
        chk("R2", {15'h0, imm_q[15]}, 16'h0);

        // With no strobe, a changing payload leaves the register alone.
        step(0, 0, 15'h7777, "R5");

        // Reset in the middle of a sequence.
        step(1, 1, 15'h1111, "R4");
        rst_n = 0; @(posedge clk); #2;
        chk("R1", imm_q, 16'h0000);
        model = '0;
        rst_n = 1;

        // Read index match.
        for (int k = 0; k < 32; k++) begin
            rd_idx = k[4:0]; #1;
            chk("R8", {15'h0, rd_hit}, {15'h0, (k == 28)});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule